// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block sits between a simple 32-bit register bus and the analog half of a 10-bit successive-approximation converter. Software selects an input channel, programs a power-up settling delay and sets a power bit. After the programmed settling time the block issues a one-cycle start pulse. It then runs a ten-step binary search by driving a trial code to the external DAC and reading back a comparator decision. When the search ends it stores the code, drops its busy flag and raises an interrupt flag that can be masked.

The register window has four words. Word 0 holds the result, word 1 the busy status, word 2 the control bits and word 3 the settling delay. Reads are combinational. Writes take effect on the clock edge on which the bus write strobe is seen. The block's clock is the converter clock. The analog DAC, comparator and sample-and-hold are outside the block.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset every register word (offsets 0x0, 0x4, 0x8, 0xC, chosen by `bus_addr[3:2]`) reads 0, and `irq` and `soc` are 0.
- R2: Word 0x0 holds the last conversion code in bits 9:0 with bits 31:10 zero. Bus writes to it have no effect.
- R3: Word 0x4 bit 0 reads 1 from the edge that writes the power bit to 1 until the edge that stores the result. It reads 0 otherwise, and bits 31:1 are zero.
- R4: Control bits 2:0 hold the channel code and drive `chan_sel`. `chan_en` is 1 for codes 0 to 5 and 0 for the reserved codes 6 and 7, which still read back as written.
- R5: Control bit 3 is the power bit. While it is 0 no conversion runs. Writing it to 1 starts exactly one conversion, and a new one needs the bit cleared and set again.
- R6: `soc` is high for exactly one cycle, which follows the (D+2)th rising edge after the edge that sets the power bit. D is the value in bits 5:0 of word 0xC.
- R7: The search tries bits from 9 down to 0. For each trial, `dac_code` shows the bits kept so far plus the trial bit. The bit is kept when `cmp_hi` is 1, meaning the input is at or above the DAC level. The stored code therefore equals the input code.
- R8: The code is stored and control bit 6 (interrupt flag) is set on the (D+13)th rising edge after the power-bit write, and busy drops on that edge.
- R9: Writing control bit 6 as 0 clears the flag. Writing it as 1 leaves the flag unchanged.
- R10: `irq` is 1 exactly when the flag (control bit 6) and the enable (control bit 5) are both 1.
- R11: Control bit 4 and bits 31:7 read as zero whatever is written. Word 0xC bits 31:6 read as zero.
- R12: Clearing the power bit during a conversion aborts it. Busy drops on that edge, the previous result is kept, and no flag or interrupt follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| chan_sel | output | 3 | Analog channel code |
| chan_en | output | 1 | Channel code is a valid input (0 to 5) |
| soc | output | 1 | One-cycle start-of-conversion pulse |
| dac_code | output | 10 | Trial code for the external DAC |
| cmp_hi | input | 1 | Comparator: input at or above DAC level |
| irq | output | 1 | Masked end-of-conversion interrupt |

## Verification
The search is tried with inputs at the extreme codes 0 and 1023 and at the adjacent midpoint codes 512 and 511. These separate a correct keep/drop decision on the MSB from an off-by-one in the comparison. Alternating patterns 0x155 and 0x2AA show that each of the ten bit positions is decided on its own step. Every channel carries a different input level, so a wrong channel mux or a wrong bit order produces a wrong code. Settling delays of 0, 1, 2, 5, 10 and 63 pin the start pulse and the completion edge to the exact D+2 and D+13 positions.

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int RES   = 10,
  parameter int DLY_W = 6,
  parameter int NCH   = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [3:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic [2:0]     chan_sel,
  output logic           chan_en,
  output logic           soc,
  output logic [RES-1:0] dac_code,
  input  logic           cmp_hi,
  output logic           irq
);
  localparam int IW = $clog2(RES);

  typedef enum logic [2:0] {S_OFF, S_WAIT, S_SOC, S_CONV, S_DONE} state_t;

  state_t           state_q;
  logic [RES-1:0]   result_q, sar_q;
  logic [IW-1:0]    idx_q;
  logic [DLY_W:0]   cnt_q;
  logic [DLY_W-1:0] dly_q;
  logic [2:0]       ch_q;
  logic             pwr_q, ien_q, flag_q;

  wire wr_ctl     = bus_wr && bus_addr[3:2] == 2'd2;
  wire wr_dly     = bus_wr && bus_addr[3:2] == 2'd3;
  wire pwr_d      = wr_ctl ? bus_wdata[3] : pwr_q;
  wire last_trial = state_q == S_CONV && idx_q == '0;
  wire busy       = state_q == S_WAIT || state_q == S_SOC || state_q == S_CONV;
  wire [RES-1:0] trial_bit = {{(RES-1){1'b0}}, 1'b1} << idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q   <= '0;
      pwr_q  <= 1'b0;
      ien_q  <= 1'b0;
      flag_q <= 1'b0;
      dly_q  <= '0;
    end else begin
      if (wr_ctl) begin
        ch_q  <= bus_wdata[2:0];
        pwr_q <= bus_wdata[3];
        ien_q <= bus_wdata[5];
      end
      if (wr_dly) dly_q <= bus_wdata[DLY_W-1:0];
      if (last_trial && pwr_d)            flag_q <= 1'b1;
      else if (wr_ctl && !bus_wdata[6])   flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_OFF;
      cnt_q    <= '0;
      idx_q    <= '0;
      sar_q    <= '0;
      result_q <= '0;
    end else if (!pwr_d) begin
      state_q <= S_OFF;
    end else begin
      case (state_q)
        S_OFF: begin
          state_q <= S_WAIT;
          cnt_q   <= '0;
        end
        S_WAIT: begin
          if (cnt_q == {1'b0, dly_q} + 1'b1) state_q <= S_SOC;
          else                               cnt_q   <= cnt_q + 1'b1;
        end
        S_SOC: begin
          state_q <= S_CONV;
          idx_q   <= IW'(RES - 1);
          sar_q   <= '0;
        end
        S_CONV: begin
          sar_q[idx_q] <= cmp_hi;
          if (idx_q == '0) begin
            result_q <= {sar_q[RES-1:1], cmp_hi};
            state_q  <= S_DONE;
          end else begin
            idx_q <= idx_q - 1'b1;
          end
        end
        default: state_q <= S_DONE;
      endcase
    end
  end

  assign dac_code = (state_q == S_CONV) ? (sar_q | trial_bit) : '0;
  assign soc      = state_q == S_SOC;
  assign chan_sel = ch_q;
  assign chan_en  = ch_q < 3'(NCH);
  assign irq      = flag_q & ien_q;

  always_comb begin
    case (bus_addr[3:2])
      2'd0:    bus_rdata = 32'(result_q);
      2'd1:    bus_rdata = {31'b0, busy};
      2'd2:    bus_rdata = {25'b0, flag_q, ien_q, 1'b0, pwr_q, ch_q};
      default: bus_rdata = 32'(dly_q);
    endcase
  end

  assert_soc_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    soc |=> !soc);
  assert_off_not_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_q |-> !busy);
  assert_result_only_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_q) |-> $past(state_q) == S_CONV);
  assert_flag_only_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(state_q) == S_CONV && state_q == S_DONE);
  assert_msb_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (soc && pwr_d) |=> dac_code == trial_bit && idx_q == IW'(RES - 1));
  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ien_q);
endmodule

// File: tb/sar_adc_ctrl_test.sv
module sar_adc_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  chan_sel;
  logic        chan_en, soc, irq;
  logic [9:0]  dac_code;
  logic [9:0]  vin [8];
  logic        cmp_hi;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  assign cmp_hi = vin[chan_sel] >= dac_code;

  sar_adc_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chan_sel(chan_sel),
    .chan_en(chan_en), .soc(soc), .dac_code(dac_code), .cmp_hi(cmp_hi),
    .irq(irq)
  );

  // {channel[2:0], delay[5:0], input[9:0]}
  localparam logic [18:0] VEC [6] = '{
    {3'd0, 6'd0,  10'd0},
    {3'd1, 6'd1,  10'd1023},
    {3'd2, 6'd5,  10'd512},
    {3'd3, 6'd63, 10'd511},
    {3'd4, 6'd2,  10'h155},
    {3'd5, 6'd10, 10'h2AA}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected below 100000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    logic [9:0]  last;
    for (int i = 0; i < 8; i++) vin[i] = 10'(37 * i + 100);
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(4'(a * 4), v);
      chk("R1 reset word", v, 32'h0);
    end
    chk("R1 irq reset", {31'b0, irq}, 0);
    chk("R1 soc reset", {31'b0, soc}, 0);

    // R11 / R4 / R9: reserved bits, reserved channel, flag write 1
    wr(4'h8, 32'hFFFF_FFF7);
    rd(4'h8, v);
    chk("R11 control reserved bits", v, 32'h27);
    chk("R4 reserved channel disables", {31'b0, chan_en}, 0);
    chk("R4 channel code readback", {29'b0, chan_sel}, 7);
    chk("R9 writing 1 does not set flag", {31'b0, v[6]}, 0);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, v);
    chk("R11 delay reserved bits", v, 32'h3F);
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, v);
    chk("R2 result write ignored", v, 0);
    wr(4'h8, 32'h0);
    step(5);
    chk("R5 no start while off", {31'b0, soc}, 0);

    // Vector table: delay, start pulse, search, completion
    for (int n = 0; n < 6; n++) begin
      int ch, d;
      ch = int'(VEC[n][18:16]);
      d  = int'(VEC[n][15:10]);
      vin[ch] = VEC[n][9:0];
      wr(4'hC, 32'(d));
      wr(4'h8, 32'h28 | 32'(ch));
      chk("R4 valid channel enabled", {31'b0, chan_en}, 1);
      for (int k = 1; k <= d + 13; k++) begin
        @(negedge clk);
        chk("R6 start pulse position", {31'b0, soc}, {31'b0, k == d + 2});
        if (k == 1 || k == d + 12) begin
          rd(4'h4, v);
          chk("R3 busy during conversion", v, 1);
        end
        if (k == d + 12) chk("R8 irq not yet", {31'b0, irq}, 0);
      end
      chk("R8 irq at completion", {31'b0, irq}, 1);
      rd(4'h0, v);
      chk("R7 stored code equals input", v, 32'(VEC[n][9:0]));
      rd(4'h4, v);
      chk("R3 busy clear after result", v, 0);
      rd(4'h8, v);
      chk("R8 flag set", {31'b0, v[6]}, 1);
      wr(4'h8, 32'h20 | 32'(ch));
      chk("R9 flag cleared by write 0", {31'b0, irq}, 0);
    end

    // R5: one conversion per power-up, R10 masking, R9 write 1 keeps flag
    vin[2] = 10'd777;
    wr(4'hC, 32'd0);
    wr(4'h8, 32'h0A);
    step(13);
    chk("R10 masked irq", {31'b0, irq}, 0);
    rd(4'h8, v);
    chk("R10 flag set while masked", {31'b0, v[6]}, 1);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (soc) chk("R5 no second start", 1, 0);
    end
    rd(4'h4, v);
    chk("R5 idle after single conversion", v, 0);
    wr(4'h8, 32'h6A);
    chk("R10 irq when enabled", {31'b0, irq}, 1);
    rd(4'h8, v);
    chk("R9 writing 1 keeps flag", {31'b0, v[6]}, 1);
    rd(4'h0, v);
    chk("R7 result channel 2", v, 777);
    last = v[9:0];
    wr(4'h8, 32'h22);

    // R12: abort mid-search
    vin[2] = 10'd5;
    wr(4'h8, 32'h2A);
    step(6);
    wr(4'h8, 32'h22);
    rd(4'h4, v);
    chk("R12 busy cleared by abort", v, 0);
    rd(4'h0, v);
    chk("R12 previous result kept", v, 32'(last));
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (irq || soc) chk("R12 nothing after abort", 1, 0);
    end
    rd(4'h8, v);
    chk("R12 no flag after abort", {31'b0, v[6]}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule